// File: doc/BRIEF.md
# Paged Virtual Address Translation Unit

This block turns a 16-bit virtual address into a 22-bit physical address, or into an 18-bit one padded out to 22 bits. It holds a separate page table for each of three privilege modes: kernel, supervisor and user. Each mode has eight instruction pages and eight data pages. Every page has a base register and a descriptor. The descriptor holds the page length, the growth direction, an access-control code and a hardware-maintained written flag.

A requester presents an address together with its privilege mode, its space (instruction or data) and its direction (read or write). One cycle later the block returns either a physical address or an abort. On the first abort it records the cause, the mode, the space and the page number in a status register. That record stays frozen until software clears the error flags. When translation is off, the address passes through unchanged, except that the top 8K of virtual space is lifted onto the I/O page at the top of physical memory. Software reaches all tables and control registers through a simple register port with an 8-bit address.

Register port addressing uses an 8-bit address:
- Bit 7 = 1 selects a control register. Address 0x80 is the status register. Address 0x81 is the configuration register.
- Bit 7 = 0 selects a page-table entry:
  - bit 6: 0 = descriptor, 1 = base
  - bits 5:4: mode index (0 = kernel, 1 = supervisor, 2 = user; 3 = unused)
  - bit 3: space (0 = instruction, 1 = data)
  - bits 2:0: page number

Top module: `page_xlate`

## Requirements
- R1: With translation on, the physical address is (base << 6) + VA[12:0]. The entry is chosen by VA[15:13], the request mode (00 kernel, 01 supervisor, 11 user) and the space. The result and the abort flag appear one cycle after req_valid. rsp_valid is high for exactly that cycle, and rsp_pa is 0 when the request aborts.
- R2: When configuration bit 4 is 0 (18-bit mode), the sum is cut to 18 bits. Physical bits 21:18 are all ones if bits 17:13 of the cut sum are all ones, and zeros otherwise. When bit 4 is 1, the full 22-bit sum is used.
- R3: Descriptor bits 2:1 are the access code. Codes 00 and 10 abort every access and set status bit 15. Code 01 aborts writes only and sets status bit 13. Code 11 never aborts.
- R4: The block number is VA[12:6]. If descriptor bit 3 is 0, a block number greater than descriptor bits 14:8 aborts. If descriptor bit 3 is 1, a block number less than that field aborts. A length abort sets status bit 14.
- R5: On an abort while status bits 15:13 are all zero, the status register loads the error flags. It also loads the request mode into bits 6:5, the space into bit 4 (I = 0, D = 1) and the page number into bits 3:1.
- R6: While status bits 15:13 are nonzero, later aborts leave the whole status register unchanged. A software write updates only bits 15:13 and bit 0 (the master enable). Setting bits 15:13 this way causes no abort.
- R7: Descriptor bit 6 is set by a write request that is translated without an abort. Any software write to that page's descriptor or base clears it. Software cannot set it.
- R8: Translation is on only when status bit 0 is 1 and the request mode's enable bit is set. The enable bits are configuration bit 2 for kernel, bit 1 for supervisor and bit 0 for user. When translation is off, the block never aborts. Addresses below 0xE000 map to the same physical value, and addresses at or above 0xE000 map to 0x3F0000 | VA.
- R9: A request with mode 10 while status bit 0 is 1 always aborts with status bit 15.
- R10: Configuration bit 5 makes data-space requests use the instruction-space entries. The configuration register reads back bits 5, 4 and 2:0, with the other bits read as 0.
- R11: A descriptor reads back only bits 14:8, 6, 3 and 2:1, with the other bits read as 0. A base reads back in full. Entries with mode index 3 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 16 | Virtual address |
| req_mode | input | 2 | Privilege mode of the access |
| req_dspace | input | 1 | 1 = data space, 0 = instruction space |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_pa | output | 22 | Physical address |
| rsp_abort | output | 1 | Access aborted |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |

## Verification
The bench builds the block with its default parameters: a 16-bit virtual address, a 22-bit physical address, an 18-bit narrow mode and 64-byte blocks. With these values, the eight-page boundary, the 8K I/O window and 18-bit truncation can all be reached with a few chosen base values. One base pushes an 18-bit sum into the top 8K so that the ones-padding shows. Another lands just below that window. Both length directions are probed at the block just inside and just outside the limit.

// File: rtl/page_xlate_pkg.sv
`timescale 1ns/1ps
package page_xlate_pkg;

    localparam logic [1:0] MODE_KERN = 2'b00;
    localparam logic [1:0] MODE_SUPV = 2'b01;
    localparam logic [1:0] MODE_BAD  = 2'b10;
    localparam logic [1:0] MODE_USER = 2'b11;

    localparam logic [1:0] ACC_NONE  = 2'b00;
    localparam logic [1:0] ACC_RDONL = 2'b01;
    localparam logic [1:0] ACC_SPARE = 2'b10;
    localparam logic [1:0] ACC_RDWR  = 2'b11;

    typedef struct packed {
        logic [6:0] plen;
        logic       written;
        logic       down;
        logic [1:0] acc;
    } desc_t;

    typedef struct packed {
        logic nonres;
        logic lenerr;
        logic roerr;
    } fault_t;

    function automatic logic [1:0] mode_index(input logic [1:0] m);
        case (m)
            MODE_KERN: mode_index = 2'd0;
            MODE_SUPV: mode_index = 2'd1;
            MODE_USER: mode_index = 2'd2;
            default:   mode_index = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/pxl_tables.sv
`timescale 1ns/1ps
module pxl_tables
    import page_xlate_pkg::*;
#(
    parameter int PG_W   = 3,
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic              sw_base,
    input  logic [1:0]        sw_midx,
    input  logic              sw_space,
    input  logic [PG_W-1:0]   sw_page,
    input  logic [15:0]       sw_wdata,
    output desc_t             sw_desc,
    output logic [BASE_W-1:0] sw_baseval,
    input  logic [1:0]        lk_midx,
    input  logic              lk_space,
    input  logic [PG_W-1:0]   lk_page,
    output desc_t             lk_desc,
    output logic [BASE_W-1:0] lk_baseval,
    input  logic              mark_we,
    input  logic [1:0]        mark_midx,
    input  logic              mark_space,
    input  logic [PG_W-1:0]   mark_page
);
    localparam int IDX_W = PG_W + 3;
    localparam int NENT  = 1 << IDX_W;

    typedef struct packed {
        desc_t [NENT-1:0]             desc;
        logic  [NENT-1:0][BASE_W-1:0] base;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [IDX_W-1:0] sw_idx, lk_idx, mark_idx;
    logic             sw_ok;

    assign sw_idx   = {sw_midx, sw_space, sw_page};
    assign lk_idx   = {lk_midx, lk_space, lk_page};
    assign mark_idx = {mark_midx, mark_space, mark_page};
    assign sw_ok    = sw_we && (sw_midx != 2'd3);

    always_comb begin
        tbl_d = tbl_q;
        if (mark_we) begin
            tbl_d.desc[mark_idx].written = 1'b1;
        end
        if (sw_ok) begin
            if (sw_base) begin
                tbl_d.base[sw_idx]         = BASE_W'(sw_wdata);
                tbl_d.desc[sw_idx].written = 1'b0;
            end else begin
                tbl_d.desc[sw_idx] = '{plen: sw_wdata[14:8], written: 1'b0,
                                       down: sw_wdata[3], acc: sw_wdata[2:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign sw_desc    = tbl_q.desc[sw_idx];
    assign sw_baseval = tbl_q.base[sw_idx];
    assign lk_desc    = tbl_q.desc[lk_idx];
    assign lk_baseval = tbl_q.base[lk_idx];

    assert_swclr_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ok |=> !tbl_q.desc[$past(sw_idx)].written);

    assert_mark_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_we && !(sw_ok && sw_idx == mark_idx)) |=> tbl_q.desc[$past(mark_idx)].written);

endmodule

// File: rtl/pxl_check.sv
`timescale 1ns/1ps
module pxl_check
    import page_xlate_pkg::*;
(
    input  desc_t      desc,
    input  logic [6:0] blk,
    input  logic       wr,
    input  logic       bad_mode,
    output fault_t     fault
);
    always_comb begin
        fault.nonres = bad_mode || (desc.acc == ACC_NONE) || (desc.acc == ACC_SPARE);
        fault.roerr  = !bad_mode && wr && (desc.acc == ACC_RDONL);
        if (bad_mode)       fault.lenerr = 1'b0;
        else if (desc.down) fault.lenerr = blk < desc.plen;
        else                fault.lenerr = blk > desc.plen;
    end
endmodule

// File: rtl/pxl_reloc.sv
`timescale 1ns/1ps
module pxl_reloc #(
    parameter int VA_W    = 16,
    parameter int PA_W    = 22,
    parameter int NARROW  = 18,
    parameter int OFS_W   = 13,
    parameter int SHIFT   = 6,
    parameter int BASE_W  = 16
) (
    input  logic [BASE_W-1:0] base,
    input  logic [VA_W-1:0]   va,
    input  logic              mapped,
    input  logic              wide,
    output logic [PA_W-1:0]   pa
);
    logic [PA_W-1:0]   sum;
    logic [NARROW-1:0] cut;
    logic              cut_io, va_io;

    always_comb begin
        sum    = PA_W'({base, {SHIFT{1'b0}}}) + PA_W'(va[OFS_W-1:0]);
        cut    = sum[NARROW-1:0];
        cut_io = &cut[NARROW-1:OFS_W];
        va_io  = &va[VA_W-1:OFS_W];
        if (!mapped)   pa = {{(PA_W-VA_W){va_io}}, va};
        else if (wide) pa = sum;
        else           pa = {{(PA_W-NARROW){cut_io}}, cut};
    end
endmodule

// File: rtl/page_xlate.sv
`timescale 1ns/1ps
module page_xlate
    import page_xlate_pkg::*;
#(
    parameter int VA_W   = 16,
    parameter int PA_W   = 22,
    parameter int NARROW = 18,
    parameter int OFS_W  = 13,
    parameter int SHIFT  = 6,
    localparam int PG_W   = VA_W - OFS_W,
    localparam int BASE_W = PA_W - SHIFT,
    localparam int ADDR_W = PG_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_mode,
    input  logic              req_dspace,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_abort,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata
);
    typedef struct packed {
        logic            rsp_valid;
        logic            rsp_abort;
        logic [PA_W-1:0] rsp_pa;
        fault_t          err;
        logic [1:0]      cap_mode;
        logic            cap_space;
        logic [PG_W-1:0] cap_page;
        logic            map_en;
        logic            en_k, en_s, en_u;
        logic            wide;
        logic            share;
    } st_t;

    st_t st_d, st_q;

    // register port decode
    logic            is_ctrl, stat_sw_we, cfg_sw_we, tbl_sw_we;
    logic            rd_base;
    logic [1:0]      rd_midx;
    logic            rd_space;
    logic [PG_W-1:0] rd_page;

    assign is_ctrl    = reg_addr[ADDR_W-1];
    assign rd_base    = reg_addr[ADDR_W-2];
    assign rd_midx    = reg_addr[PG_W+2:PG_W+1];
    assign rd_space   = reg_addr[PG_W];
    assign rd_page    = reg_addr[PG_W-1:0];
    assign stat_sw_we = reg_we && is_ctrl && !reg_addr[0];
    assign cfg_sw_we  = reg_we && is_ctrl && reg_addr[0];
    assign tbl_sw_we  = reg_we && !is_ctrl;

    // request path
    logic [1:0]        midx;
    logic              bad_mode, mode_en, mapped, lk_space, do_abort, mark_we;
    logic [PG_W-1:0]   page;
    desc_t             lk_desc, sw_desc;
    logic [BASE_W-1:0] lk_base, sw_base;
    fault_t            fault;
    logic [PA_W-1:0]   pa;

    assign midx     = mode_index(req_mode);
    assign bad_mode = (req_mode == MODE_BAD);
    assign page     = req_va[VA_W-1:OFS_W];
    assign lk_space = req_dspace && !st_q.share;

    always_comb begin
        case (req_mode)
            MODE_KERN: mode_en = st_q.en_k;
            MODE_SUPV: mode_en = st_q.en_s;
            MODE_USER: mode_en = st_q.en_u;
            default:   mode_en = 1'b1;
        endcase
    end

    assign mapped   = st_q.map_en && mode_en;
    assign do_abort = mapped && (fault.nonres || fault.lenerr || fault.roerr);
    assign mark_we  = req_valid && mapped && !do_abort && req_write && !bad_mode;

    pxl_tables #(.PG_W(PG_W), .BASE_W(BASE_W)) u_tables (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we      (tbl_sw_we),
        .sw_base    (rd_base),
        .sw_midx    (rd_midx),
        .sw_space   (rd_space),
        .sw_page    (rd_page),
        .sw_wdata   (reg_wdata),
        .sw_desc    (sw_desc),
        .sw_baseval (sw_base),
        .lk_midx    (midx),
        .lk_space   (lk_space),
        .lk_page    (page),
        .lk_desc    (lk_desc),
        .lk_baseval (lk_base),
        .mark_we    (mark_we),
        .mark_midx  (midx),
        .mark_space (lk_space),
        .mark_page  (page)
    );

    pxl_check u_check (
        .desc     (lk_desc),
        .blk      (req_va[OFS_W-1:SHIFT]),
        .wr       (req_write),
        .bad_mode (bad_mode),
        .fault    (fault)
    );

    pxl_reloc #(.VA_W(VA_W), .PA_W(PA_W), .NARROW(NARROW), .OFS_W(OFS_W),
                .SHIFT(SHIFT), .BASE_W(BASE_W)) u_reloc (
        .base   (lk_base),
        .va     (req_va),
        .mapped (mapped),
        .wide   (st_q.wide),
        .pa     (pa)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_abort = req_valid && do_abort;
        st_d.rsp_pa    = (req_valid && !do_abort) ? pa : '0;
        if (req_valid && do_abort && (st_q.err == '0)) begin
            st_d.err       = fault;
            st_d.cap_mode  = req_mode;
            st_d.cap_space = req_dspace;
            st_d.cap_page  = page;
        end
        if (stat_sw_we) begin
            st_d.err    = reg_wdata[15:13];
            st_d.map_en = reg_wdata[0];
        end
        if (cfg_sw_we) begin
            st_d.share = reg_wdata[5];
            st_d.wide  = reg_wdata[4];
            st_d.en_k  = reg_wdata[2];
            st_d.en_s  = reg_wdata[1];
            st_d.en_u  = reg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (is_ctrl) begin
            if (reg_addr[0])
                reg_rdata = {10'b0, st_q.share, st_q.wide, 1'b0, st_q.en_k, st_q.en_s, st_q.en_u};
            else
                reg_rdata = {st_q.err, 6'b0, st_q.cap_mode, st_q.cap_space,
                             3'(st_q.cap_page), st_q.map_en};
        end else if (rd_midx == 2'd3) begin
            reg_rdata = '0;
        end else if (rd_base) begin
            reg_rdata = 16'(sw_base);
        end else begin
            reg_rdata = {1'b0, sw_desc.plen, 1'b0, sw_desc.written, 2'b0,
                         sw_desc.down, sw_desc.acc, 1'b0};
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_abort = st_q.rsp_abort;
    assign rsp_pa    = st_q.rsp_pa;

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_abort_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !st_q.map_en) |=> !rsp_abort);

    assert_status_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.err != '0) && !stat_sw_we) |=>
            ($stable(st_q.err) && $stable(st_q.cap_mode) &&
             $stable(st_q.cap_space) && $stable(st_q.cap_page)));

    assert_abort_logged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_abort && !$past(stat_sw_we)) |-> (st_q.err != '0));

endmodule

// File: tb/page_xlate_tb.sv
`timescale 1ns/1ps
module page_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_va = '0;
    logic [1:0]  req_mode = '0;
    logic        req_dspace = 1'b0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [21:0] rsp_pa;
    logic        rsp_abort;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    logic [15:0] rv;

    always #5 clk = ~clk;

    page_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_mode(req_mode), .req_dspace(req_dspace), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_abort(rsp_abort),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // {va, mode, dspace, write, abort, pa}
    localparam int NV = 15;
    localparam logic [42:0] VEC [NV] = '{
        {16'h0123, 2'b00, 1'b0, 1'b0, 1'b0, 22'h004123},
        {16'h0123, 2'b00, 1'b0, 1'b1, 1'b0, 22'h004123},
        {16'h3FFF, 2'b00, 1'b0, 1'b0, 1'b0, 22'h0FDFFF},
        {16'h0010, 2'b00, 1'b1, 1'b0, 1'b0, 22'h008010},
        {16'h0010, 2'b00, 1'b1, 1'b1, 1'b1, 22'h000000},
        {16'h2000, 2'b00, 1'b1, 1'b0, 1'b1, 22'h000000},
        {16'h4000, 2'b00, 1'b1, 1'b0, 1'b1, 22'h000000},
        {16'h40C0, 2'b00, 1'b0, 1'b0, 1'b0, 22'h0000C0},
        {16'h4100, 2'b00, 1'b0, 1'b0, 1'b1, 22'h000000},
        {16'h7F00, 2'b00, 1'b0, 1'b1, 1'b0, 22'h041F00},
        {16'h7EC0, 2'b00, 1'b0, 1'b0, 1'b1, 22'h000000},
        {16'hE010, 2'b11, 1'b0, 1'b0, 1'b0, 22'h048D10},
        {16'h8008, 2'b01, 1'b1, 1'b0, 1'b0, 22'h001008},
        {16'h8008, 2'b01, 1'b0, 1'b0, 1'b1, 22'h000000},
        {16'h0000, 2'b10, 1'b0, 1'b0, 1'b1, 22'h000000}
    };

    function automatic logic [7:0] ta(input logic b, input logic [1:0] m,
                                      input logic s, input logic [2:0] p);
        return {1'b0, b, m, s, p};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        reg_addr = a;
        #1 rv = reg_rdata;
    endtask

    task automatic req(input logic [15:0] va, input logic [1:0] m,
                       input logic d, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_mode = m; req_dspace = d; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic req_chk(input string r, input logic [15:0] va, input logic [1:0] m,
                           input logic d, input logic w, input logic ab, input logic [21:0] pa);
        req(va, m, d, w);
        chk(r, {31'b0, rsp_valid}, 32'd1);
        chk(r, {31'b0, rsp_abort}, {31'b0, ab});
        chk(r, {10'b0, rsp_pa}, {10'b0, pa});
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        chk("R1 reset valid", {31'b0, rsp_valid}, 0);
        chk("R1 reset abort", {31'b0, rsp_abort}, 0);
        rd(8'h80); chk("R5 reset status", rv, 16'h0000);
        rd(8'h81); chk("R10 reset config", rv, 16'h0000);

        // setup: kernel=0 super=1 user=2
        wr(8'h81, 16'h0017);
        wr(8'h80, 16'h0001);
        wr(ta(1,0,0,0), 16'h0100); wr(ta(0,0,0,0), 16'h7F06);
        wr(ta(1,0,0,1), 16'h3F00); wr(ta(0,0,0,1), 16'h7F06);
        wr(ta(1,0,0,2), 16'h0000); wr(ta(0,0,0,2), 16'h0306);
        wr(ta(1,0,0,3), 16'h1000); wr(ta(0,0,0,3), 16'h7C0E);
        wr(ta(1,0,1,0), 16'h0200); wr(ta(0,0,1,0), 16'h7F02);
        wr(ta(0,0,1,1), 16'h7F00);
        wr(ta(0,0,1,2), 16'h7F04);
        wr(ta(1,2,0,7), 16'h1234); wr(ta(0,2,0,7), 16'h7F06);
        wr(ta(1,1,1,4), 16'h0040); wr(ta(0,1,1,4), 16'h7F06);

        // vector walk: R1 relocation, R3 access codes, R4 length, R9 bad mode
        for (int i = 0; i < NV; i++) begin
            req_chk("R1/R3/R4/R9 vector", VEC[i][42:27], VEC[i][26:25], VEC[i][24],
                    VEC[i][23], VEC[i][22], VEC[i][21:0]);
        end
        @(negedge clk);
        chk("R1 valid single cycle", {31'b0, rsp_valid}, 0);

        // R5 first abort captured (RO write, kernel D page 0), R6 later ones frozen
        rd(8'h80); chk("R5 capture", rv, 16'h2011);

        // R7 written bit
        rd(ta(0,0,0,0)); chk("R7 set by write", rv, 16'h7F46);
        rd(ta(0,0,0,3)); chk("R7 set page 3", rv, 16'h7C4E);
        rd(ta(0,0,1,0)); chk("R7 not set on abort", rv, 16'h7F02);
        wr(ta(1,0,0,0), 16'h0100);
        rd(ta(0,0,0,0)); chk("R7 cleared by base write", rv, 16'h7F06);
        wr(ta(0,0,0,3), 16'h7C4E);
        rd(ta(0,0,0,3)); chk("R7 software cannot set", rv, 16'h7C0E);

        // R6 software write to status
        wr(8'h80, 16'hE07F);
        rd(8'h80); chk("R6 sw write fields", rv, 16'hE011);
        req_chk("R6 no abort from sw set", 16'h0123, 2'b00, 0, 0, 0, 22'h004123);
        req(16'h8008, 2'b01, 0, 0);
        chk("R3 nonres abort", {31'b0, rsp_abort}, 1);
        rd(8'h80); chk("R6 frozen", rv, 16'hE011);
        wr(8'h80, 16'h0001);
        rd(8'h80); chk("R6 clear keeps capture", rv, 16'h0011);
        req(16'h8008, 2'b01, 0, 0);
        rd(8'h80); chk("R5 capture nonres", rv, 16'h8029);
        wr(8'h80, 16'h0001);
        req(16'h0000, 2'b10, 0, 0);
        chk("R9 bad mode abort", {31'b0, rsp_abort}, 1);
        rd(8'h80); chk("R9 status", rv, 16'h8041);
        wr(8'h80, 16'h0001);

        // R8 translation off
        wr(8'h80, 16'h0000);
        req_chk("R8 io page", 16'hE123, 2'b00, 0, 0, 0, 22'h3FE123);
        req_chk("R8 low pass", 16'h1234, 2'b10, 0, 1, 0, 22'h001234);
        wr(8'h80, 16'h0001);
        wr(8'h81, 16'h0013);
        req_chk("R8 kernel off", 16'h4100, 2'b00, 0, 0, 0, 22'h004100);
        req_chk("R8 user still on", 16'hE010, 2'b11, 0, 0, 0, 22'h048D10);

        // R2 18-bit mode
        wr(8'h81, 16'h0007);
        req_chk("R2 low", 16'h0123, 2'b00, 0, 0, 0, 22'h004123);
        req_chk("R2 truncate", 16'h3FFF, 2'b00, 0, 0, 0, 22'h03DFFF);
        wr(ta(1,2,0,7), 16'h0F80);
        req_chk("R2 io pad", 16'hE010, 2'b11, 0, 0, 0, 22'h3FE010);

        // R10 share I tables
        wr(8'h81, 16'h0037);
        rd(8'h81); chk("R10 config readback", rv, 16'h0037);
        req_chk("R10 D uses I", 16'h0123, 2'b00, 1, 0, 0, 22'h004123);
        req_chk("R10 D write via I", 16'h0010, 2'b00, 1, 1, 0, 22'h004010);

        // R11 readback masks
        wr(ta(0,0,1,7), 16'hFFFF);
        rd(ta(0,0,1,7)); chk("R11 desc mask", rv, 16'h7F0E);
        wr(ta(1,0,1,7), 16'hFFFF);
        rd(ta(1,0,1,7)); chk("R11 base full", rv, 16'hFFFF);
        wr(ta(1,3,0,0), 16'hABCD);
        rd(ta(1,3,0,0)); chk("R11 unused index", rv, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule